// File: doc/BRIEF.md
# Double-Sign-Bit Overflow Adder/Subtractor

This block adds or subtracts two signed two's complement operands of parameterised width. It first widens each operand by one bit, made by repeating that operand's sign bit. A non-negative value then begins with the bits 00 and a negative value begins with 11. The extended sum is formed in this doubled-sign form, and the two top bits of the sum show whether the true result fits in the operand width.

When the two top bits are equal, the result is valid. When they differ, the result has overflowed. The upper of the two bits is the true sign of the mathematical result, so the block can say which way it went out of range. It reports positive overflow, negative overflow, and the OR of the two.

For subtraction, the block inverts the subtrahend and feeds a carry-in of one. The result port carries the low N bits of the extended sum, and any carry beyond the extended width is dropped. All outputs are registered, so they appear one clock after the operands are presented. Saturation and any correction of an overflowed result are left to the user.

Top module: `dsb_addsub`

## Requirements
- R1: While `rst_n` is low, `sum`, `ovf_pos`, `ovf_neg` and `ovf` are all 0.
- R2: With `sub` = 0, `sum` one clock later equals (a + b) mod 2^W, where a and b are the signed operand values.
- R3: With `sub` = 1, `sum` one clock later equals (a − b) mod 2^W. Subtracting an operand from itself gives 0 with no overflow.
- R4: `ovf_pos` is 1 exactly when the true result is greater than 2^(W−1) − 1 (extended top bits 01). The sum of two non-negative operands never raises `ovf_neg`.
- R5: `ovf_neg` is 1 exactly when the true result is less than −2^(W−1) (extended top bits 10). The sum of two negative operands never raises `ovf_pos`.
- R6: `ovf` is 1 exactly when `ovf_pos` or `ovf_neg` is 1, and the two direction flags are never 1 together.
- R7: Adding two operands of opposite sign never raises any overflow flag.
- R8: When no overflow is flagged, bit W−1 of `sum` equals the sign of the true result (1 for negative).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | W | First operand, signed |
| op_b | input | W | Second operand (subtrahend when subtracting), signed |
| sub | input | 1 | 0 = add, 1 = subtract |
| sum | output | W | Low W bits of the extended result |
| ovf_pos | output | 1 | Result above the signed range |
| ovf_neg | output | 1 | Result below the signed range |
| ovf | output | 1 | Any overflow |

## Verification
Every output lands exactly one clock edge after the operands and `sub` are presented. The bench drives each input set on a falling edge and holds it across the next rising edge. It samples the outputs on the following falling edge, where they must reflect exactly that input set, and then drives the next set. The reference is plain integer arithmetic over the range [−8, +7], computed for the previous inputs. It covers every operand pair at W = 4 in both operations, and it calls out 5+3 and −7−2 as named cases.

// File: rtl/dsb_addsub.sv
module dsb_addsub #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf_pos,
  output logic         ovf_neg,
  output logic         ovf
);
  localparam int XW = W + 1;

  logic [XW-1:0] ext_a, ext_b, b_eff, tot;
  logic [1:0]    signs;

  assign ext_a = {op_a[W-1], op_a};
  assign ext_b = {op_b[W-1], op_b};
  assign b_eff = sub ? ~ext_b : ext_b;
  assign tot   = ext_a + b_eff + {{W{1'b0}}, sub};
  assign signs = tot[XW-1:XW-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum     <= '0;
      ovf_pos <= 1'b0;
      ovf_neg <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      sum     <= tot[W-1:0];
      ovf_pos <= (signs == 2'b01);
      ovf_neg <= (signs == 2'b10);
      ovf     <= signs[1] ^ signs[0];
    end
  end

  // R6
  combined_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf == (ovf_pos | ovf_neg));

  // R6
  one_direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_pos, ovf_neg}));

  // R7
  mixed_sign_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub && (op_a[W-1] != op_b[W-1])) |=> !ovf);

  // R4
  pos_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub && !op_a[W-1] && !op_b[W-1]) |=> !ovf_neg);

  // R5
  neg_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub && op_a[W-1] && op_b[W-1]) |=> !ovf_pos);

  // R3
  self_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub && (op_a == op_b)) |=> (sum == '0 && !ovf));
endmodule

// File: tb/tb_dsb_addsub.sv
module tb_dsb_addsub;
  localparam int W = 4;
  localparam int CLK_PERIOD = 10;
  localparam int MAXV = (1 << (W - 1)) - 1;
  localparam int MINV = -(1 << (W - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic sub = 1'b0;
  logic [W-1:0] sum;
  logic ovf_pos, ovf_neg, ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsb_addsub #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sub(sub),
    .sum(sum), .ovf_pos(ovf_pos), .ovf_neg(ovf_neg), .ovf(ovf)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (a=%0d b=%0d sub=%0d)",
               req, act, exp, $signed(op_a), $signed(op_b), sub);
    end
  endtask

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                     input string tag);
    int av, bv, t, es;
    bit ep, en;
    op_a = a; op_b = b; sub = s;
    av = int'($signed(a));
    bv = int'($signed(b));
    t  = s ? av - bv : av + bv;
    ep = (t > MAXV);
    en = (t < MINV);
    es = t & ((1 << W) - 1);
    @(negedge clk);
    chk(s ? {"R3 sum ", tag} : {"R2 sum ", tag}, int'(sum), es);
    chk({"R4 ovf_pos ", tag}, int'(ovf_pos), int'(ep));
    chk({"R5 ovf_neg ", tag}, int'(ovf_neg), int'(en));
    chk({"R6 ovf ", tag}, int'(ovf), int'(ep | en));
    if (!s && (av < 0) != (bv < 0))
      chk({"R7 opposite-sign add ", tag}, int'(ovf), 0);
    if (!ep && !en)
      chk({"R8 sign bit ", tag}, int'(sum[W-1]), int'(t < 0));
  endtask

  initial begin
    op_a = 4'd5; op_b = 4'd3; sub = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 reset sum", int'(sum), 0);
    chk("R1 reset ovf_pos", int'(ovf_pos), 0);
    chk("R1 reset ovf_neg", int'(ovf_neg), 0);
    chk("R1 reset ovf", int'(ovf), 0);
    rst_n = 1'b1;
    run(4'd5, 4'd3, 1'b0, "5+3");
    chk("R4 5+3 positive overflow", int'(ovf_pos), 1);
    run(4'b1001, 4'd2, 1'b1, "-7-2");
    chk("R5 -7-2 negative overflow", int'(ovf_neg), 1);
    run(4'b1001, 4'b1110, 1'b0, "-7+-2");
    chk("R5 -7+-2 negative overflow", int'(ovf_neg), 1);
    run(4'd7, 4'b1000, 1'b0, "7+-8");
    chk("R7 7+-8 no overflow", int'(ovf), 0);
    run(4'b1000, 4'b1000, 1'b1, "-8-(-8)");
    chk("R3 self subtract zero", int'(sum), 0);
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < (1 << W); i++)
        for (int j = 0; j < (1 << W); j++)
          run(W'(i), W'(j), 1'(s), "sweep");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule